// File: doc/BRIEF.md
# Programmable AND-OR Logic Array

This block is a sum-of-products logic array whose whole personality is loaded at run time. An 8-bit input vector passes through 24 product terms. Each term has a stored match value and a care mask. An OR plane then gives an 8-bit output vector, where each output bit picks any subset of the 24 terms. The terms are kept as three groups of eight, so each output's selection is held as three 8-bit masks: low, middle and high.

Software or a sequencer loads the personality through a plain address/data/write-enable port. It then pulses an evaluate strobe. The input is sampled on that strobe, and the result appears on a registered output together with a single-cycle completion pulse. Until the next completion, the output keeps its previous value. A partially computed result is never visible. Loading the right constants turns the array into, for example, a hexadecimal seven-segment decoder.

Top module: `pla_array`

## Requirements
- R1: Product term n is true exactly when ((inVec XOR match_n) AND care_n) is zero; input bits whose care bit is 0 do not affect the term.
- R2: A term whose care mask is all zeros is true for every input and every match value.
- R3: Output bit k is 1 when at least one selected term is true. Term t is selected when bit (t mod 8) of output k's mask for group t/8 is set. Group 0 covers terms 0–7, group 1 covers 8–15 and group 2 covers 16–23.
- R4: An output whose three selection masks are all zero evaluates to 0.
- R5: Write addresses are decoded as follows. Address n (0–23) holds the match value of term n. Address 24+n holds the care mask of term n. Address 48+3k+g holds output k's mask for group g. Bit i of a match or care value corresponds to inVec bit i.
- R6: Writes to addresses 72–127 change no configuration.
- R7: After reset all configuration is zero, yOut is 0 and doneOut is 0. An evaluation before any write therefore returns 0 on every output.
- R8: If evalStrobe is high in cycle t, doneOut is high in cycle t+2 and yOut holds the new result from cycle t+2 onward. doneOut is never high without such a strobe.
- R9: inVec is sampled only in the strobe cycle. yOut changes only in cycles where doneOut is high.
- R10: A write presented in the same cycle as evalStrobe, or in the cycle after it, is dropped. An evaluation therefore never mixes old and new configuration.
- R11: Strobes in consecutive cycles each produce their own result, on consecutive cycles with doneOut high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evalStrobe | input | 1 | One-cycle request to evaluate inVec |
| inVec | input | 8 | Array input vector |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 7 | Configuration address |
| cfgData | input | 8 | Configuration write data |
| yOut | output | 8 | Registered array output |
| doneOut | output | 1 | One-cycle pulse when yOut is updated |

## Verification
The assertions assume that rstN is held low for at least one clock edge before any strobe. They also treat the configuration as untouched only until the first write enable, whether or not that write is later dropped. The bench drives every input on the falling edge and raises the strobe only after reset is released. It keeps the write-blocking rule in its reference model, so writes that collide with an evaluation are checked rather than avoided.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
  localparam int IN_W      = 8;
  localparam int TERMS     = 24;
  localparam int OUTS      = 8;
  localparam int GRP_W     = IN_W;
  localparam int NGRP      = TERMS / GRP_W;
  localparam int CFG_DEPTH = 2 * TERMS + OUTS * NGRP;
  localparam int ADDR_W    = $clog2(CFG_DEPTH) + 0;

  typedef struct packed {
    logic loadTerms;   // register the AND plane from the live input
    logic loadOut;     // register the OR plane and raise done
    logic allowWrite;  // configuration may change this edge
  } pla_ctrl_t;
endpackage

// File: rtl/pla_control.sv
`timescale 1ns/1ps
module pla_control
  import pla_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      evalStrobe,
  output pla_ctrl_t ctrl
);
  logic stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= 1'b0;
    else       stageQ <= evalStrobe;
  end

  always_comb begin
    ctrl.loadTerms  = evalStrobe;
    ctrl.loadOut    = stageQ;
    ctrl.allowWrite = !evalStrobe && !stageQ;
  end
endmodule

// File: rtl/pla_datapath.sv
`timescale 1ns/1ps
module pla_datapath
  import pla_pkg::*;
#(
  parameter int P_IN_W   = IN_W,
  parameter int P_TERMS  = TERMS,
  parameter int P_OUTS   = OUTS,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  pla_ctrl_t           ctrl,
  input  logic [P_IN_W-1:0]   inVec,
  input  logic                cfgWe,
  input  logic [P_ADDR_W-1:0] cfgAddr,
  input  logic [P_IN_W-1:0]   cfgData,
  output logic [P_TERMS-1:0]  termQ,
  output logic [P_OUTS-1:0]   yQ,
  output logic                doneQ
);
  localparam int GW        = P_IN_W;
  localparam int NG        = P_TERMS / GW;
  localparam int CARE_BASE = P_TERMS;
  localparam int SEL_BASE  = 2 * P_TERMS;

  logic [P_IN_W-1:0]  matchQ [P_TERMS];
  logic [P_IN_W-1:0]  careQ  [P_TERMS];
  logic [P_TERMS-1:0] selQ   [P_OUTS];
  logic [P_TERMS-1:0] termNow;
  logic [P_OUTS-1:0]  outNow;
  logic               wrOk;

  assign wrOk = cfgWe && ctrl.allowWrite;

  // configuration store, decoded by address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int t = 0; t < P_TERMS; t++) begin
        matchQ[t] <= '0;
        careQ[t]  <= '0;
      end
      for (int o = 0; o < P_OUTS; o++) selQ[o] <= '0;
    end else if (wrOk) begin
      for (int t = 0; t < P_TERMS; t++) begin
        if (cfgAddr == P_ADDR_W'(t))             matchQ[t] <= cfgData;
        if (cfgAddr == P_ADDR_W'(CARE_BASE + t)) careQ[t]  <= cfgData;
      end
      for (int o = 0; o < P_OUTS; o++) begin
        for (int g = 0; g < NG; g++) begin
          if (cfgAddr == P_ADDR_W'(SEL_BASE + o * NG + g))
            selQ[o][g*GW +: GW] <= cfgData;
        end
      end
    end
  end

  // AND plane
  for (genvar t = 0; t < P_TERMS; t++) begin : g_term
    assign termNow[t] = ~|((inVec ^ matchQ[t]) & careQ[t]);
  end

  // OR plane
  for (genvar o = 0; o < P_OUTS; o++) begin : g_out
    assign outNow[o] = |(termQ & selQ[o]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termQ <= '0;
      yQ    <= '0;
      doneQ <= 1'b0;
    end else begin
      if (ctrl.loadTerms) termQ <= termNow;
      if (ctrl.loadOut)   yQ    <= outNow;
      doneQ <= ctrl.loadOut;
    end
  end
endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
  import pla_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalStrobe,
  input  logic [IN_W-1:0]   inVec,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [IN_W-1:0]   cfgData,
  output logic [OUTS-1:0]   yOut,
  output logic              doneOut
);
  pla_ctrl_t        ctrl;
  logic [TERMS-1:0] termQ;

  pla_control ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .evalStrobe(evalStrobe),
    .ctrl      (ctrl)
  );

  pla_datapath #(
    .P_IN_W  (IN_W),
    .P_TERMS (TERMS),
    .P_OUTS  (OUTS),
    .P_ADDR_W(ADDR_W)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .inVec  (inVec),
    .cfgWe  (cfgWe),
    .cfgAddr(cfgAddr),
    .cfgData(cfgData),
    .termQ  (termQ),
    .yQ     (yOut),
    .doneQ  (doneOut)
  );
endmodule

// File: rtl/pla_array_chk.sv
`timescale 1ns/1ps
module pla_array_chk #(
  parameter int C_OUTS  = 8,
  parameter int C_TERMS = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               evalStrobe,
  input logic               cfgWe,
  input logic [C_OUTS-1:0]  yOut,
  input logic               doneOut,
  input logic [C_TERMS-1:0] termQ
);
  logic cfgTouched;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgTouched <= 1'b0;
    else if (cfgWe) cfgTouched <= 1'b1;
  end

  p_done_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    evalStrobe |-> ##2 doneOut);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(evalStrobe, 2));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(yOut));

  p_reset_out_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !cfgTouched) |-> (yOut == '0));

  p_reset_terms_true_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(evalStrobe) && !cfgTouched) |-> (&termQ));
endmodule

bind pla_array pla_array_chk #(
  .C_OUTS (pla_pkg::OUTS),
  .C_TERMS(pla_pkg::TERMS)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .evalStrobe(evalStrobe),
  .cfgWe     (cfgWe),
  .yOut      (yOut),
  .doneOut   (doneOut),
  .termQ     (termQ)
);

// File: tb/pla_array_tb_top.sv
`timescale 1ns/1ps
module pla_array_tb_top;
  import pla_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, evalStrobe = 1'b0, cfgWe = 1'b0;
  logic [IN_W-1:0]   inVec = '0, cfgData = '0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [OUTS-1:0]   yOut;
  logic              doneOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  pla_array dut_i (
    .clk(clk), .rstN(rstN), .evalStrobe(evalStrobe), .inVec(inVec),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .yOut(yOut), .doneOut(doneOut)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // behavioural reference model
  logic [IN_W-1:0]  mMatch [TERMS];
  logic [IN_W-1:0]  mCare  [TERMS];
  logic [TERMS-1:0] mSel   [OUTS];
  logic             mS1 = 1'b0, mDone = 1'b0, mAllow;
  logic [IN_W-1:0]  mS1In = '0;
  logic [OUTS-1:0]  mY = '0;

  function automatic logic [OUTS-1:0] refEval(input logic [IN_W-1:0] v);
    logic [OUTS-1:0] r = '0;
    for (int k = 0; k < OUTS; k++)
      for (int t = 0; t < TERMS; t++)
        if (mSel[k][t] && (((v ^ mMatch[t]) & mCare[t]) == '0)) r[k] = 1'b1;
    return r;
  endfunction

  task automatic modelWrite(input int a, input logic [IN_W-1:0] d);
    if (a < TERMS) mMatch[a] = d;
    else if (a < 2*TERMS) mCare[a-TERMS] = d;
    else if (a < CFG_DEPTH) mSel[(a-2*TERMS)/NGRP][((a-2*TERMS)%NGRP)*GRP_W +: GRP_W] = d;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < TERMS; t++) begin mMatch[t] = '0; mCare[t] = '0; end
      for (int k = 0; k < OUTS; k++) mSel[k] = '0;
      mS1 = 1'b0; mDone = 1'b0; mY = '0;
    end else begin
      mDone = mS1;
      if (mS1) mY = refEval(mS1In);
      mAllow = !evalStrobe && !mS1;
      mS1 = evalStrobe;
      mS1In = inVec;
      if (cfgWe && mAllow) modelWrite(int'(cfgAddr), cfgData);
    end
  end

  // every-clock comparison against the model (R8, R9, R10, R11)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      checks++;
      if (yOut !== mY || doneOut !== mDone) begin
        fails++;
        $display("FAIL R8 per-cycle: y=%h done=%b expected y=%h done=%b", yOut, doneOut, mY, mDone);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] segOf(input logic [3:0] n);
    case (n)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  task automatic cfgWrite(input int a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = ADDR_W'(a); cfgData = IN_W'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic evaluate(input logic [IN_W-1:0] v, output logic [OUTS-1:0] y, output logic d);
    @(negedge clk);
    evalStrobe = 1'b1; inVec = v;
    @(negedge clk);
    evalStrobe = 1'b0;
    @(negedge clk);
    y = yOut; d = doneOut;
  endtask

  task automatic loadSevenSeg();
    for (int t = 0; t < 16; t++) begin
      cfgWrite(t, t);
      cfgWrite(TERMS + t, 8'h0F);
    end
    for (int k = 0; k < 7; k++) begin
      logic [7:0] ma = '0, mb = '0;
      for (int dg = 0; dg < 8; dg++) begin
        ma[dg] = segOf(4'(dg))[k];
        mb[dg] = segOf(4'(dg + 8))[k];
      end
      cfgWrite(2*TERMS + NGRP*k,     ma);
      cfgWrite(2*TERMS + NGRP*k + 1, mb);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  logic [OUTS-1:0] y, yKeep;
  logic d;

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset y", yOut, 0);
    chk("R7 reset done", doneOut, 0);
    rstN = 1'b1;
    evaluate(8'h5A, y, d);
    chk("R7 eval after reset y", y, 0);
    chk("R4 all masks zero", y, 0);
    chk("R8 done", d, 1);

    // R8 latency detail
    @(negedge clk); evalStrobe = 1'b1; inVec = 8'h00;
    @(negedge clk); evalStrobe = 1'b0;
    chk("R8 done not at t+1", doneOut, 0);
    @(negedge clk); chk("R8 done at t+2", doneOut, 1);
    @(negedge clk); chk("R8 done one cycle", doneOut, 0);

    // seven-segment personality, full sweep (R3, R5)
    loadSevenSeg();
    for (int v = 0; v < 256; v++) begin
      evaluate(8'(v), y, d);
      chk("R3 seven-seg", y, {1'b0, segOf(4'(v))});
    end

    // R1 exact match on term 16, output 7 group 2 bit 0
    cfgWrite(16, 8'hA5);
    cfgWrite(TERMS + 16, 8'hFF);
    cfgWrite(2*TERMS + NGRP*7 + 2, 8'h01);
    evaluate(8'hA5, y, d); chk("R1 match", y[7], 1);
    evaluate(8'hA4, y, d); chk("R1 mismatch low bit", y[7], 0);
    evaluate(8'h25, y, d); chk("R1 mismatch high bit", y[7], 0);
    cfgWrite(TERMS + 16, 8'hF0);
    evaluate(8'hAF, y, d); chk("R1 dont-care bits", y[7], 1);
    evaluate(8'hB5, y, d); chk("R1 cared bit differs", y[7], 0);
    cfgWrite(TERMS + 16, 8'h00);
    evaluate(8'h00, y, d); chk("R2 zero care true", y[7], 1);
    evaluate(8'h5C, y, d); chk("R2 zero care true again", y[7], 1);
    cfgWrite(2*TERMS + NGRP*7 + 2, 8'h00);
    evaluate(8'h5C, y, d); chk("R4 masks cleared", y[7], 0);
    cfgWrite(2*TERMS + NGRP*7 + 2, 8'h01);
    cfgWrite(TERMS + 16, 8'hFF);

    // R6 out-of-range writes
    cfgWrite(100, 8'hFF);
    cfgWrite(127, 8'hFF);
    cfgWrite(72, 8'hFF);
    evaluate(8'hA4, y, d); chk("R6 no change", y, {1'b0, segOf(4'h4)});
    evaluate(8'hA5, y, d); chk("R6 no change term16", y, {1'b1, segOf(4'h5)});

    // R10 write in strobe cycle dropped
    @(negedge clk); evalStrobe = 1'b1; inVec = 8'hA5;
    cfgWe = 1'b1; cfgAddr = ADDR_W'(2*TERMS + NGRP*7 + 2); cfgData = 8'h00;
    @(negedge clk); evalStrobe = 1'b0; cfgWe = 1'b0;
    @(negedge clk); chk("R10 same-cycle result", {doneOut, yOut[7]}, 2'b11);
    evaluate(8'hA5, y, d); chk("R10 same-cycle write dropped", y[7], 1);
    // R10 write in cycle after strobe dropped
    @(negedge clk); evalStrobe = 1'b1; inVec = 8'hA5;
    @(negedge clk); evalStrobe = 1'b0;
    cfgWe = 1'b1; cfgAddr = ADDR_W'(2*TERMS + NGRP*7 + 2); cfgData = 8'h00;
    @(negedge clk); cfgWe = 1'b0;
    chk("R10 next-cycle result", {doneOut, yOut[7]}, 2'b11);
    evaluate(8'hA5, y, d); chk("R10 next-cycle write dropped", y[7], 1);
    cfgWrite(2*TERMS + NGRP*7 + 2, 8'h00);
    evaluate(8'hA5, y, d); chk("R5 idle write accepted", y[7], 0);

    // R9 hold and single sampling
    evaluate(8'h06, y, d);
    yKeep = y;
    inVec = 8'h33;
    repeat (5) @(negedge clk);
    chk("R9 output held", yOut, yKeep);
    @(negedge clk); evalStrobe = 1'b1; inVec = 8'h02;
    @(negedge clk); evalStrobe = 1'b0; inVec = 8'h0B;
    @(negedge clk); chk("R9 input sampled once", yOut, {1'b0, segOf(4'h2)});

    // R11 back-to-back strobes
    @(negedge clk); evalStrobe = 1'b1; inVec = 8'h01;
    @(negedge clk); inVec = 8'h08;
    @(negedge clk); evalStrobe = 1'b0;
    chk("R11 first result", {doneOut, yOut}, {1'b1, 1'b0, segOf(4'h1)});
    @(negedge clk); chk("R11 second result", {doneOut, yOut}, {1'b1, 1'b0, segOf(4'h8)});
    @(negedge clk); chk("R11 done drops", doneOut, 0);

    // random personalities, full sweeps (R1, R3)
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < CFG_DEPTH; a++) cfgWrite(a, int'($urandom_range(0, 255)));
      if (r == 1) cfgWrite(TERMS + 3, 0);
      for (int v = 0; v < 256; v++) begin
        evaluate(8'(v), y, d);
        chk("R1 random config", y, refEval(8'(v)));
      end
    end

    summary();
  end
endmodule